// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives a successive-approximation converter through a run of one to eight conversions and files each result into a bank of eight result slots. A one-cycle start pulse latches the sequence length and the placement mode and begins the run. For each conversion the block raises a one-cycle start toward the converter. It then waits for the converter's done strobe and data word, stores the word, and moves on. After the last result it raises a one-cycle completion flag.

Results go to slots in one of two ways. In slot-per-position mode the n-th result of a run lands in slot n, and every run begins again at slot 0. In queue mode a write pointer keeps its place from one run to the next and wraps around the bank. A debug-active input, together with a two-bit freeze code, can let the run continue, stop it between conversions, or stop it at once. When an immediate stop aborts a conversion, that conversion is repeated on resume. The block also divides the system clock into a periodic conversion-clock enable, set by a 5-bit prescaler input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The 4-bit length code sets the number of conversions in a run: codes 1 to 7 give that many, while code 0 and any code with bit 3 set give 8. The run ends after exactly that many stored results.
- R2: With queue mode off (`fifo_mode_i`=0), the result at position k of a run (k counted from 0) is written to slot k. Each run begins at slot 0, and slots beyond the run length keep their contents.
- R3: With queue mode on, each result goes to the slot after the previous queue-mode write. The pointer keeps its value across runs, wraps from slot 7 to slot 0, and is 0 after reset.
- R4: `seq_done_o` is high for exactly one cycle, the cycle right after the clock edge that samples the done strobe of the run's last conversion, and it is low at all other times.
- R5: A `start_i` pulse during a run abandons that run. The next conversion start follows one cycle later, and its result is placed as position 0.
- R6: With freeze code 00 or 01, `dbg_active_i` has no effect and the run completes normally.
- R7: With freeze code 10 and `dbg_active_i` high, a conversion in progress is completed and stored, but no further `conv_start_o` is issued until `dbg_active_i` falls. The run then continues at the next position.
- R8: With freeze code 11, a rise of `dbg_active_i` while a conversion is outstanding aborts it. Done strobes that arrive while frozen are ignored. When `dbg_active_i` falls, the aborted position is started again and its new result is stored.
- R9: If the done strobe and an immediate freeze (code 11, `dbg_active_i` high) are sampled in the same cycle, the result is stored, then the run freezes before the next conversion start.
- R10: With `res8_i`=1 the stored word is `{2'b00, conv_data_i[9:2]}`. With `res8_i`=0 the stored word is `conv_data_i` unchanged.
- R11: `cclk_en_o` is a one-cycle pulse repeating every 2*(`prs_i`+1) system clock cycles.
- R12: After reset, all slots read 0 and `seq_done_o` and `conv_start_o` are low.
- R13: `conv_start_o` is a one-cycle pulse. No second start is issued for a conversion until its done strobe arrives or a restart or abort occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a run |
| len_code_i | input | 4 | Run length code (see R1) |
| fifo_mode_i | input | 1 | 1 = queue placement, 0 = slot-per-position placement |
| frz_mode_i | input | 2 | Freeze behaviour while debug is active |
| dbg_active_i | input | 1 | Background debug active |
| res8_i | input | 1 | 1 = 8-bit results, 0 = 10-bit results |
| prs_i | input | 5 | Conversion clock prescaler value |
| cclk_en_o | output | 1 | Conversion clock enable pulse |
| conv_start_o | output | 1 | Start request to the converter |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | 10 | Converter result word |
| results_o | output | 80 | Eight 10-bit result slots, slot k at bits [10k+9:10k] |
| seq_done_o | output | 1 | Run complete, one-cycle flag |

## Verification
The done strobe of a conversion and an immediate freeze can land on the same clock edge. The design must then store the finished result and still stop before the next start. The bench provokes this by raising the debug input and the done strobe on the same falling edge while a conversion is outstanding. It then checks that the slot holds the new word, that no start appears while debug stays high, and that the run resumes at the following position rather than repeating the stored one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE  = 2'd1,
      ST_WAIT   = 2'd2,
      ST_FROZEN = 2'd3
   } seq_state_e;

   // Freeze codes
   localparam logic [1:0] FRZ_RUN  = 2'b00;
   localparam logic [1:0] FRZ_RSVD = 2'b01;
   localparam logic [1:0] FRZ_SOFT = 2'b10;
   localparam logic [1:0] FRZ_HARD = 2'b11;

endpackage

// File: rtl/adc_cclk_div.sv
module adc_cclk_div #(
   parameter int PRS_W   = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [PRS_W-1:0] prs_i,
   output logic             cclk_en_o
);

   localparam int CNT_W = PRS_W + 1;

   if (PRS_W < 1) begin : g_bad_prs
      $error("adc_cclk_div: PRS_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic             wrap;

   // half period of PRS+1 cycles -> full period 2*(PRS+1)
   assign term = {prs_i, 1'b1};
   assign wrap = (cnt_q >= term);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   if (REG_OUT) begin : g_reg_out
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) en_q <= 1'b0;
         else         en_q <= wrap;
      end
      assign cclk_en_o = en_q;
   end else begin : g_comb_out
      assign cclk_en_o = wrap;
   end

   assert_cclk_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cclk_en_o |=> !cclk_en_o);

endmodule

// File: rtl/adc_len_decode.sv
module adc_len_decode #(
   parameter int LEN_W = 4,
   parameter int CNT_W = 4
) (
   input  logic [LEN_W-1:0] code_i,
   output logic [CNT_W-1:0] count_o
);

   localparam int MAX_LEN = 2 ** (LEN_W - 1);

   if (LEN_W < 2) begin : g_bad_len
      $error("adc_len_decode: LEN_W must be at least 2");
   end
   if ((2 ** CNT_W) <= MAX_LEN) begin : g_bad_cnt
      $error("adc_len_decode: CNT_W too narrow for the longest run");
   end

   always_comb begin
      if (code_i[LEN_W-1] || (code_i == '0)) begin
         count_o = CNT_W'(MAX_LEN);
      end else begin
         count_o = CNT_W'(code_i[LEN_W-2:0]);
      end
      assert_len_range_R1: assert ((count_o >= CNT_W'(1)) && (count_o <= CNT_W'(MAX_LEN)))
         else $error("run length out of range");
   end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NUM_SLOTS = 8,
   parameter int RES_W     = 10,
   parameter int IDX_W     = 3
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_en_i,
   input  logic [IDX_W-1:0]           wr_idx_i,
   input  logic [RES_W-1:0]           wr_data_i,
   output logic [NUM_SLOTS*RES_W-1:0] results_o
);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("adc_result_bank: at least two slots required");
   end
   if ((2 ** IDX_W) < NUM_SLOTS) begin : g_bad_idx
      $error("adc_result_bank: IDX_W too narrow");
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [RES_W-1:0] slot_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            slot_q <= '0;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(s))) begin
            slot_q <= wr_data_i;
         end
      end
      assign results_o[s*RES_W +: RES_W] = slot_q;
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int RES_W     = 10,
   parameter int NARROW_W  = 8,
   parameter int LEN_W     = 4,
   parameter int PRS_W     = 5
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       start_i,
   input  logic [LEN_W-1:0]           len_code_i,
   input  logic                       fifo_mode_i,
   input  logic [1:0]                 frz_mode_i,
   input  logic                       dbg_active_i,
   input  logic                       res8_i,
   input  logic [PRS_W-1:0]           prs_i,
   output logic                       cclk_en_o,
   output logic                       conv_start_o,
   input  logic                       conv_done_i,
   input  logic [RES_W-1:0]           conv_data_i,
   output logic [NUM_SLOTS*RES_W-1:0] results_o,
   output logic                       seq_done_o
);

   localparam int IDX_W = $clog2(NUM_SLOTS);
   localparam int CNT_W = $clog2(NUM_SLOTS + 1);
   localparam int PAD_W = RES_W - NARROW_W;

   if (NUM_SLOTS != (2 ** (LEN_W - 1))) begin : g_bad_geom
      $error("adc_seq_ctrl: NUM_SLOTS must equal the longest coded run");
   end
   if (PAD_W < 1) begin : g_bad_narrow
      $error("adc_seq_ctrl: NARROW_W must be below RES_W");
   end

   seq_state_e       state_q;
   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] len_q;
   logic             fifo_q;
   logic [IDX_W-1:0] fifo_ptr_q;
   logic [CNT_W-1:0] len_dec;
   logic [CNT_W-1:0] pos_nxt;
   logic             last_conv;
   logic             halt_soft;
   logic             halt_hard;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [RES_W-1:0] wr_data;

   adc_cclk_div #(
      .PRS_W   (PRS_W),
      .REG_OUT (1'b1)
   ) i_cclk_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .prs_i     (prs_i),
      .cclk_en_o (cclk_en_o)
   );

   adc_len_decode #(
      .LEN_W (LEN_W),
      .CNT_W (CNT_W)
   ) i_len_decode (
      .code_i  (len_code_i),
      .count_o (len_dec)
   );

   // codes 10 and 11 both stop between conversions; only 11 aborts
   assign halt_soft = dbg_active_i && frz_mode_i[1];
   assign halt_hard = dbg_active_i && (frz_mode_i == FRZ_HARD);

   assign pos_nxt   = pos_q + CNT_W'(1);
   assign last_conv = (pos_nxt == len_q);

   assign conv_start_o = (state_q == ST_ISSUE) && !halt_soft;
   assign wr_en        = (state_q == ST_WAIT) && conv_done_i && !start_i;
   assign wr_idx       = fifo_q ? fifo_ptr_q : pos_q[IDX_W-1:0];
   assign wr_data      = res8_i ? {{PAD_W{1'b0}}, conv_data_i[RES_W-1 -: NARROW_W]}
                                : conv_data_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         pos_q      <= '0;
         len_q      <= '0;
         fifo_q     <= 1'b0;
         fifo_ptr_q <= '0;
         seq_done_o <= 1'b0;
      end else begin
         seq_done_o <= 1'b0;
         if (start_i) begin
            state_q <= ST_ISSUE;
            pos_q   <= '0;
            len_q   <= len_dec;
            fifo_q  <= fifo_mode_i;
         end else begin
            unique case (state_q)
               ST_ISSUE: begin
                  state_q <= halt_soft ? ST_FROZEN : ST_WAIT;
               end
               ST_WAIT: begin
                  if (conv_done_i) begin
                     pos_q <= pos_nxt;
                     if (fifo_q) fifo_ptr_q <= fifo_ptr_q + IDX_W'(1);
                     if (last_conv) begin
                        state_q    <= ST_IDLE;
                        seq_done_o <= 1'b1;
                     end else begin
                        state_q <= halt_hard ? ST_FROZEN : ST_ISSUE;
                     end
                  end else if (halt_hard) begin
                     state_q <= ST_FROZEN;
                  end
               end
               ST_FROZEN: begin
                  if (!halt_soft) state_q <= ST_ISSUE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   adc_result_bank #(
      .NUM_SLOTS (NUM_SLOTS),
      .RES_W     (RES_W),
      .IDX_W     (IDX_W)
   ) i_result_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .results_o (results_o)
   );

   assert_done_follows_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_done_o |-> ($past(conv_done_i) && !$past(start_i)));

   assert_start_single_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_start_o && !start_i) |=> !conv_start_o);

   assert_hard_freeze_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(halt_hard && !start_i) && halt_hard) |-> !conv_start_o);

   assert_fifo_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && fifo_q && (fifo_ptr_q == IDX_W'(NUM_SLOTS - 1))) |=> (fifo_ptr_q == '0));

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  len_code_i = 4'd1;
   logic        fifo_mode_i = 1'b0;
   logic [1:0]  frz_mode_i = 2'b00;
   logic        dbg_active_i = 1'b0;
   logic        res8_i = 1'b0;
   logic [4:0]  prs_i = 5'd5;
   logic        cclk_en_o;
   logic        conv_start_o;
   logic        conv_done_i = 1'b0;
   logic [9:0]  conv_data_i = '0;
   logic [79:0] results_o;
   logic        seq_done_o;

   int nchecks = 0;
   int nfail   = 0;
   bit finished = 1'b0;

   always #5 clk_i = ~clk_i;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start_i),
      .len_code_i   (len_code_i),
      .fifo_mode_i  (fifo_mode_i),
      .frz_mode_i   (frz_mode_i),
      .dbg_active_i (dbg_active_i),
      .res8_i       (res8_i),
      .prs_i        (prs_i),
      .cclk_en_o    (cclk_en_o),
      .conv_start_o (conv_start_o),
      .conv_done_i  (conv_done_i),
      .conv_data_i  (conv_data_i),
      .results_o    (results_o),
      .seq_done_o   (seq_done_o)
   );

   function automatic logic [9:0] slot(input int i);
      return results_o[i*10 +: 10];
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk_i) start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
   endtask

   task automatic wait_start(input string req);
      int n = 0;
      while (!conv_start_o && n < 200) begin
         @(negedge clk_i);
         n++;
      end
      if (n >= 200) check(1'b0, req, 32'd0, 32'd1);
   endtask

   // answer one conversion: wait for its start, then strobe done in WAIT
   task automatic do_conv(input logic [9:0] d, input string req);
      wait_start(req);
      @(negedge clk_i);
      check(!conv_start_o, "R13 single start", 32'(conv_start_o), 32'd0);
      conv_done_i = 1'b1;
      conv_data_i = d;
      @(negedge clk_i);
      conv_done_i = 1'b0;
   endtask

   task automatic run_seq(input int code, input int n, input logic [9:0] base, input string req);
      len_code_i = 4'(code);
      pulse_start();
      for (int i = 0; i < n; i++) begin
         do_conv(base + 10'(i), req);
         if (i < n - 1) check(!seq_done_o, {req, " no early done"}, 32'(seq_done_o), 32'd0);
      end
      check(seq_done_o, {req, " R4 done after last"}, 32'(seq_done_o), 32'd1);
      @(negedge clk_i);
      check(!seq_done_o, "R4 done one cycle", 32'(seq_done_o), 32'd0);
      check(!conv_start_o, {req, " run ended"}, 32'(conv_start_o), 32'd0);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 8; i++) check(slot(i) == 10'd0, "R12 slot reset", 32'(slot(i)), 32'd0);
      check(!seq_done_o, "R12 done low", 32'(seq_done_o), 32'd0);
      check(!conv_start_o, "R12 start low", 32'(conv_start_o), 32'd0);
   endtask

   task automatic measure(input int p);
      int n;
      prs_i = 5'(p);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk_i);
         while (!cclk_en_o) @(negedge clk_i);
      end
      n = 0;
      do begin
         @(negedge clk_i);
         n++;
      end while (!cclk_en_o);
      check(n == 2 * (p + 1), "R11 cclk period", 32'(n), 32'(2 * (p + 1)));
   endtask

   task automatic t_cclk();
      measure(0);
      measure(5);
      measure(31);
      prs_i = 5'd5;
   endtask

   task automatic t_length();
      run_seq(1, 1, 10'h010, "R1 code1");
      run_seq(7, 7, 10'h020, "R1 code7");
      run_seq(0, 8, 10'h030, "R1 code0");
      run_seq(9, 8, 10'h040, "R1 code9");
   endtask

   task automatic t_fixed();
      run_seq(3, 3, 10'h0A1, "R2 first");
      run_seq(2, 2, 10'h0B1, "R2 second");
      check(slot(0) == 10'h0B1, "R2 slot0", 32'(slot(0)), 32'h0B1);
      check(slot(1) == 10'h0B2, "R2 slot1", 32'(slot(1)), 32'h0B2);
      check(slot(2) == 10'h0A3, "R2 slot2 kept", 32'(slot(2)), 32'h0A3);
   endtask

   task automatic t_fifo();
      fifo_mode_i = 1'b1;
      run_seq(3, 3, 10'h301, "R3 first");
      run_seq(6, 6, 10'h311, "R3 second");
      fifo_mode_i = 1'b0;
      check(slot(0) == 10'h316, "R3 wrap slot0", 32'(slot(0)), 32'h316);
      check(slot(1) == 10'h302, "R3 slot1 kept", 32'(slot(1)), 32'h302);
      check(slot(2) == 10'h303, "R3 slot2", 32'(slot(2)), 32'h303);
      check(slot(3) == 10'h311, "R3 slot3 carry", 32'(slot(3)), 32'h311);
      check(slot(7) == 10'h315, "R3 slot7", 32'(slot(7)), 32'h315);
   endtask

   task automatic t_restart();
      len_code_i = 4'd4;
      pulse_start();
      do_conv(10'h1A1, "R5");
      do_conv(10'h1A2, "R5");
      wait_start("R5");
      @(negedge clk_i);
      pulse_start();
      check(conv_start_o, "R5 restart start", 32'(conv_start_o), 32'd1);
      do_conv(10'h1B0, "R5");
      check(slot(0) == 10'h1B0, "R5 position 0", 32'(slot(0)), 32'h1B0);
      check(!seq_done_o, "R5 no done", 32'(seq_done_o), 32'd0);
      do_conv(10'h1B1, "R5");
      do_conv(10'h1B2, "R5");
      do_conv(10'h1B3, "R5");
      check(seq_done_o, "R5 done after four", 32'(seq_done_o), 32'd1);
      check(slot(1) == 10'h1B1, "R5 slot1", 32'(slot(1)), 32'h1B1);
      @(negedge clk_i);
   endtask

   task automatic t_run_through();
      dbg_active_i = 1'b1;
      frz_mode_i = 2'b00;
      run_seq(2, 2, 10'h051, "R6 code00");
      frz_mode_i = 2'b01;
      run_seq(2, 2, 10'h061, "R6 code01");
      check(slot(1) == 10'h062, "R6 stored", 32'(slot(1)), 32'h062);
      dbg_active_i = 1'b0;
      frz_mode_i = 2'b00;
   endtask

   task automatic t_soft();
      bit quiet = 1'b1;
      frz_mode_i = 2'b10;
      len_code_i = 4'd3;
      pulse_start();
      do_conv(10'h201, "R7");
      wait_start("R7");
      @(negedge clk_i);
      dbg_active_i = 1'b1;
      @(negedge clk_i);
      conv_done_i = 1'b1;
      conv_data_i = 10'h202;
      @(negedge clk_i);
      conv_done_i = 1'b0;
      for (int i = 0; i < 6; i++) begin
         if (conv_start_o) quiet = 1'b0;
         @(negedge clk_i);
      end
      check(quiet, "R7 no start while frozen", 32'(!quiet), 32'd0);
      check(slot(1) == 10'h202, "R7 in-flight stored", 32'(slot(1)), 32'h202);
      dbg_active_i = 1'b0;
      do_conv(10'h203, "R7");
      check(seq_done_o, "R7 done after resume", 32'(seq_done_o), 32'd1);
      check(slot(2) == 10'h203, "R7 slot2", 32'(slot(2)), 32'h203);
      frz_mode_i = 2'b00;
      @(negedge clk_i);
   endtask

   task automatic t_hard();
      bit quiet = 1'b1;
      logic [9:0] old1;
      frz_mode_i = 2'b11;
      len_code_i = 4'd3;
      pulse_start();
      do_conv(10'h111, "R8");
      old1 = slot(1);
      wait_start("R8");
      @(negedge clk_i);
      dbg_active_i = 1'b1;
      @(negedge clk_i);
      conv_done_i = 1'b1;
      conv_data_i = 10'h3AA;
      @(negedge clk_i);
      conv_done_i = 1'b0;
      for (int i = 0; i < 5; i++) begin
         if (conv_start_o) quiet = 1'b0;
         @(negedge clk_i);
      end
      check(quiet, "R8 no start while frozen", 32'(!quiet), 32'd0);
      check(slot(1) == old1, "R8 late done ignored", 32'(slot(1)), 32'(old1));
      dbg_active_i = 1'b0;
      do_conv(10'h122, "R8");
      check(!seq_done_o, "R8 aborted position rerun", 32'(seq_done_o), 32'd0);
      check(slot(1) == 10'h122, "R8 slot1 rerun", 32'(slot(1)), 32'h122);
      do_conv(10'h133, "R8");
      check(seq_done_o, "R8 done", 32'(seq_done_o), 32'd1);
      check(slot(2) == 10'h133, "R8 slot2", 32'(slot(2)), 32'h133);
      frz_mode_i = 2'b00;
      @(negedge clk_i);
   endtask

   task automatic t_collide();
      bit quiet = 1'b1;
      frz_mode_i = 2'b11;
      len_code_i = 4'd2;
      pulse_start();
      wait_start("R9");
      @(negedge clk_i);
      dbg_active_i = 1'b1;
      conv_done_i = 1'b1;
      conv_data_i = 10'h1C3;
      @(negedge clk_i);
      conv_done_i = 1'b0;
      check(slot(0) == 10'h1C3, "R9 result kept", 32'(slot(0)), 32'h1C3);
      check(!seq_done_o, "R9 no done", 32'(seq_done_o), 32'd0);
      for (int i = 0; i < 4; i++) begin
         if (conv_start_o) quiet = 1'b0;
         @(negedge clk_i);
      end
      check(quiet, "R9 frozen after store", 32'(!quiet), 32'd0);
      dbg_active_i = 1'b0;
      do_conv(10'h1C4, "R9");
      check(seq_done_o, "R9 next position ends run", 32'(seq_done_o), 32'd1);
      check(slot(1) == 10'h1C4, "R9 slot1", 32'(slot(1)), 32'h1C4);
      frz_mode_i = 2'b00;
      @(negedge clk_i);
   endtask

   task automatic t_res8();
      res8_i = 1'b1;
      run_seq(1, 1, 10'h3FF, "R10 narrow");
      check(slot(0) == 10'h0FF, "R10 narrow all ones", 32'(slot(0)), 32'h0FF);
      run_seq(1, 1, 10'h2A5, "R10 narrow");
      check(slot(0) == 10'h0A9, "R10 narrow pattern", 32'(slot(0)), 32'h0A9);
      res8_i = 1'b0;
      run_seq(1, 1, 10'h2A5, "R10 wide");
      check(slot(0) == 10'h2A5, "R10 wide pattern", 32'(slot(0)), 32'h2A5);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_cclk();
      t_length();
      t_fixed();
      t_fifo();
      t_restart();
      t_run_through();
      t_soft();
      t_hard();
      t_collide();
      t_res8();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         nchecks++;
         nfail++;
         $display("FAIL R13 watchdog: actual 0x0 expected 0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
         $finish;
      end
   end

endmodule